// File: doc/BRIEF.md
# Masked-Write GPIO Block with Shared Interrupt

This block provides sixteen general-purpose pins behind a small register interface. Software sets which pins drive with a direction register. It changes pin levels through a write-only output port. Each word written to that port carries its own per-pin update mask, so any subset of pins can be set or cleared in one write without first reading them. A read-only state register returns the pin levels sampled on the previous active cycle.

The eight upper pins can also raise one shared, active-high interrupt. Each of those pins is gated by its own enable bit, and the gated terms are ORed into a registered request. A two-bit control register gates the whole block. One bit enables the block clock and the other holds the block in reset. After power-up the block sits in reset with its clock off, which is the low-power state. Writing 3 and then 1 brings it into operation.

Top module: `mgp_top`

## Requirements
- R1: After `rst_n` is asserted, the control register reads 2 (reset held, clock off), `pin_oe` and `pin_out` are 0 and `shared_irq` is 0.
- R2: The control register at offset 0x14 holds bit 0 = clock enable and bit 1 = block reset. It can be written and read in every state, and bits 31:2 read as 0.
- R3: While control bit 1 is 1, the direction, output and interrupt-enable registers, the sampled pin state and `shared_irq` are forced to 0 from the next cycle on, and writes to them are ignored.
- R4: While control is 0 (clock off, reset released), writes to offsets 0x00, 0x08 and 0x10 are ignored, and the sampled pin state and `shared_irq` keep their values.
- R5: Direction register at offset 0x00: bit n = 1 drives `pin_oe[n]` high. The register reads back in bits 15:0.
- R6: Output port at offset 0x08: a write updates pin n to data bit n only where data bit 16+n is 1. Other pins keep their level. Reads return 0.
- R7: Pin-state register at offset 0x0C returns in bits 15:0 the `pin_in` value sampled on the previous active cycle. Writes to it have no effect.
- R8: Interrupt-enable register at offset 0x10 holds bits 7:0, bit i belonging to pin 8+i. Bits 31:8 are ignored on write and read as 0.
- R9: `shared_irq` is the registered OR of `pin_in[8+i] & enable[i]`, visible one cycle after the input changes. Pins 0 to 7 never contribute.
- R10: Writing 3 and then 1 to the control register leaves the block running with all pin registers cleared, and later writes take effect.
- R11: A register write takes effect on the clock edge that accepts it. `reg_rdata` follows `reg_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| pin_in | input | 16 | Pin levels from the pads |
| pin_out | output | 16 | Pin drive levels |
| pin_oe | output | 16 | Pin output enables |
| shared_irq | output | 1 | Shared interrupt request from pins 8 to 15 |

## Verification
The bench builds the block with its default parameters: sixteen pins, the shared group starting at pin 8, and an 8-bit offset. At that size the 32-bit write word splits exactly into mask and value halves. Every pin in the shared group can be probed on its own against a mixed enable pattern, and the low-pin group can be shown to have no effect on the request. The vectors walk the block through running, clock-gated, reset and bring-up states, so each gating rule is checked against live register contents.

// File: rtl/mgp_pkg.sv
package mgp_pkg;

  localparam logic [7:0] OFS_DIR   = 8'h00;
  localparam logic [7:0] OFS_OUT   = 8'h08;
  localparam logic [7:0] OFS_STATE = 8'h0C;
  localparam logic [7:0] OFS_IEN   = 8'h10;
  localparam logic [7:0] OFS_CTL   = 8'h14;

  // bit 1 = hold block in reset, bit 0 = clock enable
  typedef struct packed {
    logic rst_hold;
    logic clk_on;
  } ctl_t;

  localparam ctl_t CTL_POWERUP = '{rst_hold: 1'b1, clk_on: 1'b0};

endpackage

// File: rtl/mgp_ctrl.sv
module mgp_ctrl
  import mgp_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [1:0]        wbits,
  output ctl_t              ctl_q,
  output logic              ctl_we,
  output logic              blk_rst,
  output logic              blk_run
);

  assign ctl_we = reg_wr && (reg_addr == ADDR_W'(OFS_CTL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= CTL_POWERUP;
    else if (ctl_we) ctl_q <= ctl_t'(wbits);
  end

  // reset takes priority over the clock enable
  assign blk_rst = ctl_q.rst_hold;
  assign blk_run = ctl_q.clk_on && !ctl_q.rst_hold;

endmodule

// File: rtl/mgp_regs.sv
module mgp_regs
  import mgp_pkg::*;
#(
  parameter int NPIN   = 16,
  parameter int NSH    = 8,
  parameter int ADDR_W = 8,
  localparam int DW    = 2 * NPIN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blk_rst,
  input  logic              blk_run,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [NPIN-1:0]   dir_q,
  output logic [NPIN-1:0]   out_q,
  output logic [NSH-1:0]    ien_q,
  output logic              out_we
);

  function automatic logic [NPIN-1:0] masked_merge(
    input logic [NPIN-1:0] prev,
    input logic [NPIN-1:0] sel,
    input logic [NPIN-1:0] val
  );
    return (prev & ~sel) | (val & sel);
  endfunction

  logic dir_we, ien_we;

  assign dir_we = blk_run && reg_wr && (reg_addr == ADDR_W'(OFS_DIR));
  assign out_we = blk_run && reg_wr && (reg_addr == ADDR_W'(OFS_OUT));
  assign ien_we = blk_run && reg_wr && (reg_addr == ADDR_W'(OFS_IEN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
      ien_q <= '0;
    end else if (blk_rst) begin
      dir_q <= '0;
      out_q <= '0;
      ien_q <= '0;
    end else begin
      if (dir_we) dir_q <= reg_wdata[NPIN-1:0];
      if (out_we) out_q <= masked_merge(out_q, reg_wdata[DW-1:NPIN], reg_wdata[NPIN-1:0]);
      if (ien_we) ien_q <= reg_wdata[NSH-1:0];
    end
  end

endmodule

// File: rtl/mgp_sense.sv
module mgp_sense #(
  parameter int NPIN  = 16,
  parameter int SH_LO = 8,
  localparam int NSH  = NPIN - SH_LO
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            blk_rst,
  input  logic            blk_run,
  input  logic [NPIN-1:0] pin_in,
  input  logic [NSH-1:0]  ien_q,
  output logic [NPIN-1:0] pin_q,
  output logic            irq_q
);

  logic [NSH-1:0] grp_hit;

  for (genvar gi = 0; gi < NSH; gi++) begin : g_grp
    assign grp_hit[gi] = pin_in[SH_LO+gi] & ien_q[gi];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= '0;
      irq_q <= 1'b0;
    end else if (blk_rst) begin
      pin_q <= '0;
      irq_q <= 1'b0;
    end else if (blk_run) begin
      pin_q <= pin_in;
      irq_q <= |grp_hit;
    end
  end

endmodule

// File: rtl/mgp_top.sv
module mgp_top
  import mgp_pkg::*;
#(
  parameter int NUM_PINS  = 16,
  parameter int SHARED_LO = 8,
  parameter int ADDR_W    = 8,
  localparam int DW       = 2 * NUM_PINS,
  localparam int NSH      = NUM_PINS - SHARED_LO
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DW-1:0]       reg_wdata,
  output logic [DW-1:0]       reg_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                shared_irq
);

  ctl_t                ctl_q;
  logic [1:0]          ctl_bits;
  logic                ctl_we, blk_rst, blk_run, out_we;
  logic [NUM_PINS-1:0] dir_q, out_q, pin_q;
  logic [NSH-1:0]      ien_q;

  mgp_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .wbits(reg_wdata[1:0]), .ctl_q(ctl_q), .ctl_we(ctl_we),
    .blk_rst(blk_rst), .blk_run(blk_run)
  );

  mgp_regs #(.NPIN(NUM_PINS), .NSH(NSH), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .blk_rst(blk_rst), .blk_run(blk_run),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .dir_q(dir_q), .out_q(out_q), .ien_q(ien_q), .out_we(out_we)
  );

  mgp_sense #(.NPIN(NUM_PINS), .SH_LO(SHARED_LO)) u_sense (
    .clk(clk), .rst_n(rst_n), .blk_rst(blk_rst), .blk_run(blk_run),
    .pin_in(pin_in), .ien_q(ien_q), .pin_q(pin_q), .irq_q(shared_irq)
  );

  assign ctl_bits = ctl_q;
  assign pin_out  = out_q;
  assign pin_oe   = dir_q;

  always_comb begin
    unique case (reg_addr)
      ADDR_W'(OFS_DIR):   reg_rdata = DW'(dir_q);
      ADDR_W'(OFS_STATE): reg_rdata = DW'(pin_q);
      ADDR_W'(OFS_IEN):   reg_rdata = DW'(ien_q);
      ADDR_W'(OFS_CTL):   reg_rdata = DW'(ctl_bits);
      default:            reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/mgp_checker.sv
module mgp_checker #(
  parameter int NPIN = 16,
  parameter int NSH  = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ctl_we,
  input logic            blk_rst,
  input logic            blk_run,
  input logic            out_we,
  input logic [1:0]      ctl_bits,
  input logic [1:0]      wbits,
  input logic [NPIN-1:0] wmask,
  input logic [NSH-1:0]  ien_q,
  input logic [NSH-1:0]  grp_pins,
  input logic [NPIN-1:0] pin_out,
  input logic [NPIN-1:0] pin_oe,
  input logic            shared_irq
);

  AST_CTL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> ctl_bits == $past(wbits)); // R2

  AST_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    blk_rst |=> (pin_oe == '0 && pin_out == '0 && shared_irq == 1'b0)); // R3

  AST_GATE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!blk_rst && !blk_run) |=> ($stable(pin_oe) && $stable(pin_out) && $stable(shared_irq))); // R4

  AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    out_we |=> (((pin_out ^ $past(pin_out)) & ~$past(wmask)) == '0)); // R6

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shared_irq) |-> $past(|(grp_pins & ien_q))); // R9

endmodule

bind mgp_top mgp_checker #(.NPIN(NUM_PINS), .NSH(NSH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .blk_rst(blk_rst),
  .blk_run(blk_run), .out_we(out_we), .ctl_bits(ctl_bits),
  .wbits(reg_wdata[1:0]), .wmask(reg_wdata[DW-1:NUM_PINS]),
  .ien_q(ien_q), .grp_pins(pin_in[NUM_PINS-1:SHARED_LO]),
  .pin_out(pin_out), .pin_oe(pin_oe), .shared_irq(shared_irq)
);

// File: tb/test_mgp_top.sv
`timescale 1ns/1ps
module test_mgp_top;

  localparam logic [2:0] K_WR = 3'd0, K_PIN = 3'd1, K_RD = 3'd2, K_IRQ = 3'd3, K_DRV = 3'd4;
  localparam logic [7:0] A_DIR = 8'h00, A_OUT = 8'h08, A_ST = 8'h0C, A_IEN = 8'h10, A_CTL = 8'h14;

  typedef struct packed {
    logic [2:0]  kind;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  function automatic vec_t mk(input logic [2:0] k, input logic [7:0] a,
                              input logic [31:0] d, input logic [31:0] e, input logic [3:0] r);
    return '{kind: k, addr: a, data: d, exp: e, req: r};
  endfunction

  localparam int NV = 58;
  localparam vec_t VEC [NV] = '{
    mk(K_WR,  A_CTL, 32'h3, 0, 10),            // R10 bring-up step 1
    mk(K_WR,  A_CTL, 32'h1, 0, 10),            // R10 bring-up step 2
    mk(K_RD,  A_CTL, 0, 32'h1, 2),             // R2
    mk(K_RD,  A_DIR, 0, 32'h0, 10),            // R10 cleared
    mk(K_WR,  A_DIR, 32'h0000_00FF, 0, 5),     // R5
    mk(K_RD,  A_DIR, 0, 32'h0000_00FF, 5),     // R5
    mk(K_DRV, 0, 0, 32'h00FF_0000, 5),         // R5
    mk(K_WR,  A_OUT, 32'hFFFF_A5A5, 0, 6),     // R6 full mask
    mk(K_DRV, 0, 0, 32'h00FF_A5A5, 6),         // R6
    mk(K_WR,  A_OUT, 32'h00F0_0000, 0, 6),     // R6 partial clear
    mk(K_DRV, 0, 0, 32'h00FF_A505, 6),         // R6
    mk(K_WR,  A_OUT, 32'h0000_FFFF, 0, 6),     // R6 empty mask
    mk(K_DRV, 0, 0, 32'h00FF_A505, 6),         // R6
    mk(K_RD,  A_OUT, 0, 32'h0, 6),             // R6 write-only
    mk(K_PIN, 0, 32'h1234, 0, 7),              // R7
    mk(K_RD,  A_ST, 0, 32'h1234, 7),           // R7
    mk(K_WR,  A_ST, 32'hFFFF_FFFF, 0, 7),      // R7 write ignored
    mk(K_RD,  A_ST, 0, 32'h1234, 7),           // R7
    mk(K_WR,  A_IEN, 32'hFFFF_FF05, 0, 8),     // R8
    mk(K_RD,  A_IEN, 0, 32'h05, 8),            // R8
    mk(K_PIN, 0, 32'h0100, 0, 9),              // R9 pin 8 enabled
    mk(K_IRQ, 0, 0, 32'h1, 9),
    mk(K_PIN, 0, 32'h0200, 0, 9),              // R9 pin 9 disabled
    mk(K_IRQ, 0, 0, 32'h0, 9),
    mk(K_PIN, 0, 32'h00FF, 0, 9),              // R9 low pins
    mk(K_IRQ, 0, 0, 32'h0, 9),
    mk(K_PIN, 0, 32'h0400, 0, 9),              // R9 pin 10 enabled
    mk(K_IRQ, 0, 0, 32'h1, 9),
    mk(K_WR,  A_CTL, 32'h0, 0, 4),             // R4 clock off
    mk(K_RD,  A_CTL, 0, 32'h0, 2),             // R2
    mk(K_WR,  A_DIR, 32'hFFFF, 0, 4),          // R4
    mk(K_WR,  A_OUT, 32'hFFFF_0000, 0, 4),     // R4
    mk(K_DRV, 0, 0, 32'h00FF_A505, 4),         // R4
    mk(K_WR,  A_IEN, 32'h0, 0, 4),             // R4
    mk(K_PIN, 0, 32'h0000, 0, 4),              // R4
    mk(K_IRQ, 0, 0, 32'h1, 4),                 // R4 frozen
    mk(K_RD,  A_ST, 0, 32'h0400, 4),           // R4 frozen
    mk(K_WR,  A_CTL, 32'h1, 0, 4),             // R4 clock on
    mk(K_RD,  A_IEN, 0, 32'h05, 4),            // R4 write was ignored
    mk(K_PIN, 0, 32'h0000, 0, 9),              // R9
    mk(K_IRQ, 0, 0, 32'h0, 9),
    mk(K_RD,  A_ST, 0, 32'h0, 7),              // R7
    mk(K_WR,  A_CTL, 32'h2, 0, 3),             // R3 reset, clock off
    mk(K_PIN, 0, 32'h0100, 0, 3),              // R3
    mk(K_DRV, 0, 0, 32'h0, 3),                 // R3
    mk(K_IRQ, 0, 0, 32'h0, 3),                 // R3
    mk(K_RD,  A_IEN, 0, 32'h0, 3),             // R3
    mk(K_RD,  A_DIR, 0, 32'h0, 3),             // R3
    mk(K_RD,  A_ST, 0, 32'h0, 3),              // R3
    mk(K_WR,  A_DIR, 32'hF, 0, 3),             // R3 ignored
    mk(K_RD,  A_DIR, 0, 32'h0, 3),             // R3
    mk(K_RD,  A_CTL, 0, 32'h2, 2),             // R2
    mk(K_WR,  A_CTL, 32'h3, 0, 10),            // R10
    mk(K_WR,  A_CTL, 32'hFFFF_FFFD, 0, 2),     // R2 upper bits dropped
    mk(K_RD,  A_CTL, 0, 32'h1, 2),             // R2
    mk(K_RD,  A_DIR, 0, 32'h0, 10),            // R10
    mk(K_WR,  A_DIR, 32'h3, 0, 10),            // R10
    mk(K_DRV, 0, 0, 32'h0003_0000, 10)         // R10
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_out, pin_oe;
  logic        shared_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mgp_top i_mgp_top (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .shared_irq(shared_irq)
  );

  task automatic check(input int req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic rd_check(input int req, input logic [7:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    check(req, "read", reg_rdata, exp);
  endtask

  task automatic run_vec(input vec_t v);
    case (v.kind)
      K_WR: begin
        reg_wr = 1'b1; reg_addr = v.addr; reg_wdata = v.data;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0;
      end
      K_PIN: begin
        pin_in = v.data[15:0];
        @(posedge clk); @(negedge clk);
      end
      K_RD:  rd_check(int'(v.req), v.addr, v.exp);
      K_IRQ: check(int'(v.req), "shared_irq", {31'b0, shared_irq}, v.exp);
      default: check(int'(v.req), "oe/out", {pin_oe, pin_out}, v.exp);
    endcase
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 state after reset
    rd_check(1, A_CTL, 32'h2);
    check(1, "oe/out after reset", {pin_oe, pin_out}, 32'h0);
    check(1, "irq after reset", {31'b0, shared_irq}, 32'h0);

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R11: write visible only after the accepting edge
    reg_wr = 1'b1; reg_addr = A_DIR; reg_wdata = 32'h5;
    #2;
    check(11, "oe before edge", {16'b0, pin_oe}, 32'h3);
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
    check(11, "oe after edge", {16'b0, pin_oe}, 32'h5);
    rd_check(11, A_DIR, 32'h5);

    // R1: reset in mid-operation
    pin_in = 16'hFF00;
    rst_n = 1'b0;
    @(negedge clk);
    check(1, "oe/out in reset", {pin_oe, pin_out}, 32'h0);
    rd_check(1, A_CTL, 32'h2);
    rst_n = 1'b1;
    @(negedge clk);
    check(1, "irq after reset", {31'b0, shared_irq}, 32'h0);
    rd_check(1, A_DIR, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule